// File: doc/BRIEF.md
# Edge Timestamp Capture Unit with Auxiliary PWM

This block stamps transitions on a single input pin with the value of a free-running counter that advances once per system clock. Four capture slots fill in turn as qualified events arrive, so software can read a burst of four timestamps and compute periods and duty cycles. Each slot in the rotation picks its own edge direction, a prescaler can thin the event stream, and any slot can restart the counter from zero after it captures, which yields intervals directly instead of absolute times. Capture either wraps around forever or halts after a chosen slot until software re-arms it.

The same counter and slots can be switched into a PWM generator. Slot 0 then holds the active period and slot 1 the active compare, while slots 2 and 3 act as their staging copies and are copied over at each period match. A sync input can preload the counter from a phase register, which lets several units be aligned. Sticky flags record every capture, counter overflow, period match and compare match; a plain read/write port reaches all state.

Top module: `evcap_unit`

## Requirements
- R1: After reset the counter, phase, all four slots, the control word and all flags read zero, and `pwm_out` and `sync_out` are low.
- R2: With control bit 0 (run) set the counter rises by one per clock; a bus write to address 0 loads it; a step from all-ones to zero sets flag bit 4.
- R3: With control bit 1 (capture enable) set and PWM mode off, qualified events store the counter into slots 0,1,2,3 (addresses 2 to 5) in that order, wrapping back to slot 0, and set flag bit equal to the slot number.
- R4: Control bit 6+k selects the falling edge for slot k; a clear bit selects the rising edge.
- R5: Control bits 18:14 hold a value N; only every (N+1)th edge of the selected kind becomes an event.
- R6: With control bit 2 (one-shot) set, capture stops after the slot numbered in control bits 4:3 is filled; later edges change no slot and set no flag until a control write with bit 20 set, which returns the rotation to slot 0 and clears the prescaler.
- R7: With control bit 10+k set, the counter restarts at zero in the cycle after slot k captures, so a slot filled D cycles after the previous event reads D-1.
- R8: With control bit 19 set, a high `sync_in` loads the phase register (address 1) into the counter; with it clear the pin is ignored. Outside PWM mode `sync_out` repeats `sync_in` one clock later.
- R9: With control bit 5 (PWM mode) and run set, the counter returns to zero after equalling slot 0 (period P), `pwm_out` goes high at that wrap and low when the counter equals slot 1 (compare C), giving C+1 high clocks in every P+1; flag bits 5 and 6 record period and compare matches.
- R10: In PWM mode, each period match copies slot 2 into slot 0 and slot 3 into slot 1.
- R11: Writing ones to the flag register (address 7) clears those bits; a read request returns data with `bus_rvalid` exactly one clock later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cap_in | input | 1 | Asynchronous pin whose edges are timestamped |
| sync_in | input | 1 | Phase preload request |
| sync_out | output | 1 | Sync passed on to the next unit |
| pwm_out | output | 1 | PWM waveform in PWM mode, low otherwise |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read request |
| bus_addr | input | 3 | Register word address |
| bus_wdata | input | CNT_W | Write data |
| bus_rdata | output | CNT_W | Read data, valid with bus_rvalid |
| bus_rvalid | output | 1 | Read data valid, one clock after bus_rd |
| evt_flags | output | 7 | Sticky flags: slot captures 3:0, overflow 4, period 5, compare 6 |

## Verification
A pin edge reaches a slot three clocks after it is driven (two synchronizer stages and one edge stage), counter loads from the bus or sync appear on the next edge, the PWM output moves one clock after a match, and read data arrives one clock after the request. The bench drives pin edges a fixed number of clocks apart and compares differences between slots, so the constant pipeline delay cancels, and it waits several clocks after the last edge before reading. Reads go through a scoreboard queue that the monitor pops only when `bus_rvalid` is seen, and PWM duty is counted over a window of whole periods so the start phase does not matter.

// File: rtl/evcap_pkg.sv
// Shared constants and the control-word layout of the capture unit.
// Assumes a 3-bit word address and four capture slots.
package evcap_pkg;
    localparam int NEVT    = 4;
    localparam int IW      = $clog2(NEVT);
    localparam int PRESC_W = 5;
    localparam int ADDR_W  = 3;
    localparam int NFLAG   = NEVT + 3;

    localparam logic [ADDR_W-1:0] A_CNT   = 3'd0;
    localparam logic [ADDR_W-1:0] A_PHS   = 3'd1;
    localparam logic [ADDR_W-1:0] A_SLOT0 = 3'd2;
    localparam logic [ADDR_W-1:0] A_CTRL  = 3'd6;
    localparam logic [ADDR_W-1:0] A_FLAG  = 3'd7;

    localparam int F_OVF     = NEVT;
    localparam int F_PRD     = NEVT + 1;
    localparam int F_CMP     = NEVT + 2;
    localparam int REARM_BIT = 20;

    // Control word, bit 0 at the bottom (run).
    typedef struct packed {
        logic               sync_en;   // 19
        logic [PRESC_W-1:0] presc;     // 18:14
        logic [NEVT-1:0]    diff_rst;  // 13:10
        logic [NEVT-1:0]    fall;      // 9:6
        logic               pwm_mode;  // 5
        logic [IW-1:0]      stop_evt;  // 4:3
        logic               oneshot;   // 2
        logic               cap_en;    // 1
        logic               run;       // 0
    } ctrl_t;

    localparam int CTRL_W = $bits(ctrl_t);
endpackage

// File: rtl/evcap_edge_presc.sv
// Synchronizes the pin, detects the edge kind chosen for the current slot
// and passes every (presc+1)th such edge on as an event pulse.
// Assumes sig_in is asynchronous; adds a fixed three-clock latency.
module evcap_edge_presc #(
    parameter int NEVT = 4,
    parameter int PW   = 5,
    localparam int IW  = $clog2(NEVT)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            sig_in,
    input  logic [NEVT-1:0] fall_sel,
    input  logic [IW-1:0]   slot_idx,
    input  logic            enable,
    input  logic            restart,
    input  logic [PW-1:0]   presc,
    output logic            evt
);
    logic [2:0]    sh_q;
    logic [PW-1:0] div_q;
    logic          rise, fall, qual;

    // Two-stage synchronizer plus one stage of history for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= {sh_q[1:0], sig_in};
    end

    // Pick the edge kind the pending slot asks for.
    always_comb begin
        rise = sh_q[1] & ~sh_q[2];
        fall = ~sh_q[1] & sh_q[2];
        qual = fall_sel[slot_idx] ? fall : rise;
        evt  = enable & qual & (div_q == presc) & ~restart;
    end

    // Prescale counter over qualifying edges.
    always_ff @(posedge clk) begin
        if (!rst_n || restart || !enable) div_q <= '0;
        else if (qual)                    div_q <= (div_q == presc) ? '0 : div_q + 1'b1;
    end

    // R5
    presc_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (evt && presc != '0) |=> (!evt || presc != $past(presc)));
endmodule

// File: rtl/evcap_seq.sv
// Rotating slot pointer with one-shot stop. cap_vld marks an accepted event
// and ptr names the slot it fills. Assumes NEVT slots.
module evcap_seq #(
    parameter int NEVT = 4,
    localparam int IW  = $clog2(NEVT)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          evt,
    input  logic          oneshot,
    input  logic [IW-1:0] stop_evt,
    input  logic          restart,
    output logic          cap_vld,
    output logic [IW-1:0] ptr
);
    logic stopped_q;

    // An event counts only while the rotation is not halted.
    assign cap_vld = evt & ~stopped_q;

    // Advance the pointer per capture, halt on the stop slot in one-shot.
    always_ff @(posedge clk) begin
        if (!rst_n || restart) begin
            ptr       <= '0;
            stopped_q <= 1'b0;
        end else if (cap_vld) begin
            ptr <= (ptr == IW'(NEVT - 1)) ? '0 : ptr + 1'b1;
            if (oneshot && ptr == stop_evt) stopped_q <= 1'b1;
        end
    end

    // R3
    ptr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cap_vld && !restart && ptr != IW'(NEVT - 1)) |=> ptr == $past(ptr) + 1'b1);

    // R6
    oneshot_halt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cap_vld && oneshot && ptr == stop_evt && !restart) |=> !cap_vld);
endmodule

// File: rtl/evcap_pwm.sv
// Period and compare match detection and the PWM output register.
// Assumes the counter is cleared by the parent on a period match.
module evcap_pwm #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         mode,
    input  logic         run,
    input  logic [W-1:0] cnt,
    input  logic [W-1:0] prd,
    input  logic [W-1:0] cmp,
    output logic         prd_hit,
    output logic         cmp_hit,
    output logic         pwm_out
);
    // Matches exist only while PWM mode runs.
    assign prd_hit = mode & run & (cnt == prd);
    assign cmp_hit = mode & run & (cnt == cmp);

    // High at the period wrap, low at compare; compare wins a tie.
    always_ff @(posedge clk) begin
        if (!rst_n || !mode) pwm_out <= 1'b0;
        else if (cmp_hit)    pwm_out <= 1'b0;
        else if (prd_hit)    pwm_out <= 1'b1;
    end

    // R9
    pwm_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pwm_out) |-> $past(prd_hit));

    // R9
    pwm_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(pwm_out) |-> ($past(cmp_hit) || !$past(mode)));
endmodule

// File: rtl/evcap_unit.sv
// Four-slot edge timestamp unit with an auxiliary PWM mode.
// Holds the counter, phase, slots, control and flags, and the register port.
// Assumes synchronous active-low reset and CNT_W >= 21.
module evcap_unit
    import evcap_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cap_in,
    input  logic              sync_in,
    output logic              sync_out,
    output logic              pwm_out,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [CNT_W-1:0]  bus_wdata,
    output logic [CNT_W-1:0]  bus_rdata,
    output logic              bus_rvalid,
    output logic [NFLAG-1:0]  evt_flags
);
    ctrl_t             ctrl_q;
    logic [CNT_W-1:0]  cnt_q, phase_q, rd_mux;
    logic [CNT_W-1:0]  slot_q [NEVT];
    logic [NFLAG-1:0]  flags_q, flag_set, flag_clr;
    logic [IW-1:0]     ptr;
    logic              evt, cap_vld, prd_hit, cmp_hit;
    logic              wr_cnt, wr_ctrl, wr_phs, wr_flag, rearm;
    logic              sync_ld, diff_hit, ovf_hit, cap_enable;

    // Decode writes and derived strobes.
    always_comb begin
        wr_cnt     = bus_wr && bus_addr == A_CNT;
        wr_phs     = bus_wr && bus_addr == A_PHS;
        wr_ctrl    = bus_wr && bus_addr == A_CTRL;
        wr_flag    = bus_wr && bus_addr == A_FLAG;
        rearm      = wr_ctrl && bus_wdata[REARM_BIT];
        cap_enable = ctrl_q.cap_en & ~ctrl_q.pwm_mode;
        sync_ld    = sync_in & ctrl_q.sync_en;
        diff_hit   = cap_vld & ctrl_q.diff_rst[ptr];
        ovf_hit    = ctrl_q.run & (cnt_q == '1) & ~wr_cnt & ~sync_ld & ~prd_hit & ~diff_hit;
    end

    evcap_edge_presc #(.NEVT(NEVT), .PW(PRESC_W)) u_edge (
        .clk(clk), .rst_n(rst_n), .sig_in(cap_in), .fall_sel(ctrl_q.fall),
        .slot_idx(ptr), .enable(cap_enable), .restart(rearm),
        .presc(ctrl_q.presc), .evt(evt)
    );

    evcap_seq #(.NEVT(NEVT)) u_seq (
        .clk(clk), .rst_n(rst_n), .evt(evt), .oneshot(ctrl_q.oneshot),
        .stop_evt(ctrl_q.stop_evt), .restart(rearm), .cap_vld(cap_vld), .ptr(ptr)
    );

    evcap_pwm #(.W(CNT_W)) u_pwm (
        .clk(clk), .rst_n(rst_n), .mode(ctrl_q.pwm_mode), .run(ctrl_q.run),
        .cnt(cnt_q), .prd(slot_q[0]), .cmp(slot_q[1]),
        .prd_hit(prd_hit), .cmp_hit(cmp_hit), .pwm_out(pwm_out)
    );

    // Counter: bus load, then sync preload, then run (wrap or restart or step).
    always_ff @(posedge clk) begin
        if (!rst_n)                      cnt_q <= '0;
        else if (wr_cnt)                 cnt_q <= bus_wdata;
        else if (sync_ld)                cnt_q <= phase_q;
        else if (prd_hit || diff_hit)    cnt_q <= '0;
        else if (ctrl_q.run)             cnt_q <= cnt_q + 1'b1;
    end

    // Control and phase registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q  <= '0;
            phase_q <= '0;
        end else begin
            if (wr_ctrl) ctrl_q  <= ctrl_t'(bus_wdata[CTRL_W-1:0]);
            if (wr_phs)  phase_q <= bus_wdata;
        end
    end

    // Capture slots; the lower half reload from the upper half on a period match.
    for (genvar i = 0; i < NEVT; i++) begin : g_slot
        localparam bit HAS_SH = (i < NEVT / 2);
        always_ff @(posedge clk) begin
            if (!rst_n)                                   slot_q[i] <= '0;
            else if (bus_wr && bus_addr == ADDR_W'(A_SLOT0 + i)) slot_q[i] <= bus_wdata;
            else if (HAS_SH && prd_hit)                   slot_q[i] <= slot_q[(i + NEVT / 2) % NEVT];
            else if (cap_vld && ptr == IW'(i))            slot_q[i] <= cnt_q;
        end
    end

    // Flags: hardware sets win over write-one-to-clear.
    always_comb begin
        flag_set = {cmp_hit, prd_hit, ovf_hit, NEVT'({{(NEVT-1){1'b0}}, cap_vld} << ptr)};
        flag_clr = wr_flag ? bus_wdata[NFLAG-1:0] : '0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) flags_q <= '0;
        else        flags_q <= (flags_q & ~flag_clr) | flag_set;
    end

    assign evt_flags = flags_q;

    // Read data selection.
    always_comb begin
        case (bus_addr)
            A_CNT:   rd_mux = cnt_q;
            A_PHS:   rd_mux = phase_q;
            A_CTRL:  rd_mux = {{(CNT_W-CTRL_W){1'b0}}, ctrl_q};
            A_FLAG:  rd_mux = {{(CNT_W-NFLAG){1'b0}}, flags_q};
            default: rd_mux = slot_q[IW'(bus_addr - A_SLOT0)];
        endcase
    end

    // Registered read port and sync output.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bus_rvalid <= 1'b0;
            bus_rdata  <= '0;
            sync_out   <= 1'b0;
        end else begin
            bus_rvalid <= bus_rd;
            if (bus_rd) bus_rdata <= rd_mux;
            sync_out   <= ctrl_q.pwm_mode ? prd_hit : sync_in;
        end
    end

    // R2
    ovf_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flags_q[F_OVF]) |-> $past(cnt_q) == '1);

    // R11
    rd_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rd |=> bus_rvalid);

    // R11
    rd_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rvalid |-> $past(bus_rd));
endmodule

// File: tb/evcap_unit_tb.sv
`timescale 1ns/1ps
module evcap_unit_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cap_in = 1'b0, sync_in = 1'b0;
    logic        sync_out, pwm_out;
    logic        bus_wr = 1'b0, bus_rd = 1'b0;
    logic [2:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        bus_rvalid;
    logic [6:0]  evt_flags;

    int          checks = 0, errors = 0;
    bit          done = 1'b0;
    logic [31:0] last_rd;

    typedef struct {
        string       tag;
        logic [31:0] exp;
        bit          cmp;
    } sb_item_t;
    sb_item_t sb_q[$];

    always #2.5 clk = ~clk;

    evcap_unit u_dut (
        .clk(clk), .rst_n(rst_n), .cap_in(cap_in), .sync_in(sync_in),
        .sync_out(sync_out), .pwm_out(pwm_out), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .bus_rvalid(bus_rvalid), .evt_flags(evt_flags)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Monitor: pop the scoreboard whenever read data is presented.
    always @(negedge clk) begin
        if (bus_rvalid) begin
            if (sb_q.size() == 0) begin
                chk("R11 unexpected rvalid", 32'd1, 32'd0);
            end else begin
                sb_item_t it = sb_q.pop_front();
                last_rd = bus_rdata;
                if (it.cmp) chk(it.tag, bus_rdata, it.exp);
            end
        end
    end

    function automatic logic [31:0] mk(input bit run, input bit cap, input bit one,
                                       input int stop, input bit pwm, input int fall,
                                       input int diff, input int presc, input bit syn,
                                       input bit rearm);
        return 32'(run) | (32'(cap) << 1) | (32'(one) << 2) | (32'(stop) << 3) |
               (32'(pwm) << 5) | (32'(fall) << 6) | (32'(diff) << 10) |
               (32'(presc) << 14) | (32'(syn) << 19) | (32'(rearm) << 20);
    endfunction

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic issue_rd(input logic [2:0] a, input string tag,
                            input logic [31:0] exp, input bit cmp);
        sb_item_t it;
        it.tag = tag; it.exp = exp; it.cmp = cmp;
        sb_q.push_back(it);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = a;
        @(negedge clk);
        bus_rd = 1'b0;
        #1;
    endtask

    task automatic expect_reg(input logic [2:0] a, input logic [31:0] exp, input string tag);
        issue_rd(a, tag, exp, 1'b1);
    endtask

    task automatic read_reg(input logic [2:0] a, output logic [31:0] d);
        issue_rd(a, "", '0, 1'b0);
        d = last_rd;
    endtask

    task automatic train(input int n, input int d, input int h);
        for (int k = 0; k < n; k++) begin
            cap_in = 1'b1;
            repeat (h) @(negedge clk);
            cap_in = 1'b0;
            repeat (d - h) @(negedge clk);
        end
        repeat (6) @(negedge clk);
    endtask

    task automatic count_high(output int n);
        n = 0;
        for (int k = 0; k < 100; k++) begin
            @(negedge clk);
            if (pwm_out) n++;
        end
    endtask

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [31:0] a, b, c, d, old0;
        int hi;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        chk("R1 pwm_out", {31'b0, pwm_out}, 32'd0);
        chk("R1 sync_out", {31'b0, sync_out}, 32'd0);
        expect_reg(3'd0, 32'd0, "R1 counter");
        expect_reg(3'd2, 32'd0, "R1 slot0");
        expect_reg(3'd6, 32'd0, "R1 ctrl");
        expect_reg(3'd7, 32'd0, "R1 flags");

        // R2 stopped counter holds a loaded value, running counter steps
        wr(3'd0, 32'd100);
        expect_reg(3'd0, 32'd100, "R2 load while stopped");
        wr(3'd6, mk(1,0,0,0,0,0,0,0,0,0));
        read_reg(3'd0, a);
        read_reg(3'd0, b);
        chk("R2 step per clock", b - a, 32'd2);
        wr(3'd0, 32'hFFFF_FFF0);
        repeat (30) @(negedge clk);
        expect_reg(3'd7, 32'h10, "R2 overflow flag");
        // R11 write-one-to-clear
        wr(3'd7, 32'h10);
        expect_reg(3'd7, 32'h0, "R11 flag cleared");

        // R3 continuous rotation with wrap
        wr(3'd0, 32'd0);
        wr(3'd6, mk(1,1,0,0,0,0,0,0,0,1));
        wr(3'd7, 32'h7F);
        train(5, 12, 4);
        read_reg(3'd2, a); read_reg(3'd3, b); read_reg(3'd4, c); read_reg(3'd5, d);
        chk("R3 slot2-slot1", c - b, 32'd12);
        chk("R3 slot3-slot2", d - c, 32'd12);
        chk("R3 wrap slot0-slot3", a - d, 32'd12);
        expect_reg(3'd7, 32'h0F, "R3 event flags");

        // R4 per-slot polarity: slots 0 and 2 falling
        wr(3'd6, mk(1,1,1,3,0,4'b0101,0,0,0,1));
        train(3, 20, 6);
        read_reg(3'd2, a); read_reg(3'd3, b); read_reg(3'd4, c); read_reg(3'd5, d);
        chk("R4 fall0 to rise1", b - a, 32'd14);
        chk("R4 rise1 to fall2", c - b, 32'd6);
        chk("R4 fall2 to rise3", d - c, 32'd14);

        // R5 prescale by two
        wr(3'd6, mk(1,1,1,3,0,0,0,1,0,1));
        train(8, 10, 3);
        read_reg(3'd2, a); read_reg(3'd3, b); read_reg(3'd4, c); read_reg(3'd5, d);
        chk("R5 slot1-slot0", b - a, 32'd20);
        chk("R5 slot3-slot2", d - c, 32'd20);

        // R6 one-shot stop after slot 1, then re-arm
        wr(3'd6, mk(1,1,1,1,0,0,0,0,0,1));
        wr(3'd4, 32'd0);
        wr(3'd5, 32'd0);
        wr(3'd7, 32'h7F);
        train(4, 10, 3);
        read_reg(3'd2, a); read_reg(3'd3, b);
        chk("R6 captured pair", b - a, 32'd10);
        expect_reg(3'd4, 32'd0, "R6 slot2 untouched after stop");
        expect_reg(3'd7, 32'h03, "R6 no flags after stop");
        old0 = a;
        wr(3'd6, mk(1,1,1,3,0,0,0,0,0,1));
        train(2, 10, 3);
        read_reg(3'd2, a); read_reg(3'd3, b);
        chk("R6 rearmed slot0 advanced", {31'b0, a > old0}, 32'd1);
        chk("R6 rearmed pair", b - a, 32'd10);
        expect_reg(3'd4, 32'd0, "R6 slot2 still untouched");

        // R7 counter restart on every slot
        wr(3'd6, mk(1,1,0,0,0,0,4'hF,0,0,1));
        train(5, 15, 5);
        expect_reg(3'd2, 32'd14, "R7 slot0 interval");
        expect_reg(3'd3, 32'd14, "R7 slot1 interval");
        expect_reg(3'd5, 32'd14, "R7 slot3 interval");

        // R8 sync preload, ignored when disabled, repeated on sync_out
        wr(3'd6, mk(0,0,0,0,0,0,0,0,0,0));
        wr(3'd1, 32'h1234_5678);
        wr(3'd0, 32'd5);
        @(negedge clk); sync_in = 1'b1;
        @(negedge clk); sync_in = 1'b0;
        expect_reg(3'd0, 32'd5, "R8 sync ignored when disabled");
        wr(3'd6, mk(0,0,0,0,0,0,0,0,1,0));
        @(negedge clk); sync_in = 1'b1;
        @(negedge clk);
        chk("R8 sync_out follows", {31'b0, sync_out}, 32'd1);
        sync_in = 1'b0;
        @(negedge clk);
        chk("R8 sync_out drops", {31'b0, sync_out}, 32'd0);
        expect_reg(3'd0, 32'h1234_5678, "R8 phase loaded");

        // R9 PWM duty, R10 staging transfer
        wr(3'd2, 32'd9); wr(3'd3, 32'd4); wr(3'd4, 32'd9); wr(3'd5, 32'd4);
        wr(3'd0, 32'd0);
        wr(3'd7, 32'h7F);
        wr(3'd6, mk(1,0,0,0,1,0,0,0,0,0));
        repeat (40) @(negedge clk);
        count_high(hi);
        chk("R9 duty C+1 of P+1", 32'(hi), 32'd50);
        read_reg(3'd7, a);
        chk("R9 match flags", (a >> 5) & 32'h3, 32'h3);
        wr(3'd5, 32'd6);
        repeat (30) @(negedge clk);
        count_high(hi);
        chk("R10 staged compare applied", 32'(hi), 32'd70);
        expect_reg(3'd3, 32'd6, "R10 active compare");

        repeat (5) @(negedge clk);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule